// File: doc/BRIEF.md
# Amplifier Power-Mode and Fault Supervisor

This block decides the operating mode of a class-D output stage: shutdown, sleep, muted idle or active playback. It combines an external active-low shutdown pin, register-side control bits (shutdown, sleep, mute), a supply-window flag and four raw fault indications. From these it drives the power-stage enable and the ramp requests to the volume block. It also drives a four-bit fault status and an active-low open-drain fault indication.

Over-temperature, DC-content and over-current faults are latched and hold the stage in sleep until either shutdown control is pulsed low. The stage is then held off for a recovery interval: a shorter one for a DC fault alone, a longer one when over-temperature or over-current was latched. A clock error forces sleep without a volume ramp and recovers by itself. Before the first entry to active after shutdown it only pulses the fault output; after that entry it holds the fault output low. Intervals count a microsecond tick, and every count is a parameter.

Top module: `amp_mode_supervisor`

## Requirements
- R1: The block is in shutdown (mode 0, stage disabled) whenever `shdnPinN` or `shdnBitN` is low or `supplyOk` is low. It leaves shutdown only when all three are high. Mode encoding: 0 shutdown, 1 sleep, 2 muted idle, 3 active, 4 ramping down.
- R2: Out of shutdown with `sleepBit` high, the mode is sleep with the stage disabled. With `sleepBit` low and `muteBit` high, the mode is muted idle with the stage enabled. With both low, the mode is active, and `rampUpReq` is high for exactly the first cycle in active.
- R3: A request for shutdown, sleep or mute while active enters mode 4, where `rampDownReq` is high and the stage stays enabled until `rampDone` is seen. The block then moves to the requested mode.
- R4: A raw over-temperature, DC or over-current input sets status bit 0, 1 or 2 respectively and forces sleep on the next clock edge. Toggling the sleep bit does not clear these bits. Only a low level on `shdnPinN` or `shdnBitN` clears them.
- R5: A raw clock error forces sleep on the next edge with no ramp-down, and status bit 3 follows it. When the error goes away, the block returns to the previous playback mode with a ramp-up request.
- R6: Status bit 3 reads 1 while the mode is shutdown, with no clock error present.
- R7: With a clock error present outside shutdown, `faultN` is driven low for `PULSE_LOW` ticks of every `PULSE_PERIOD` ticks if active has not been reached since the last shutdown. Once active has been reached, `faultN` is held low continuously.
- R8: After latched faults are cleared, `faultN` stays low and active is blocked for `SHORT_WAIT` ticks if only the DC bit was set. The interval is `LONG_WAIT` ticks if the over-temperature or over-current bit was set.
- R9: A supply dropout forces shutdown at once, keeps any latched status bits and, once the supply is back, resumes without further action.
- R10: During reset the mode is shutdown, the stage is disabled, no ramp is requested, `faultN` is 1 and the status reads 4'b1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| usTick | input | 1 | One-cycle pulse per microsecond |
| shdnPinN | input | 1 | External shutdown pin, low = shut down |
| shdnBitN | input | 1 | Register shutdown bit, low = shut down |
| sleepBit | input | 1 | Register sleep request |
| muteBit | input | 1 | Register mute request |
| supplyOk | input | 1 | Supply is inside its valid window |
| rawOverTemp | input | 1 | Over-temperature detector |
| rawDcErr | input | 1 | Output DC-content detector |
| rawOverCur | input | 1 | Over-current detector |
| rawClkErr | input | 1 | Audio clock error detector |
| rampDone | input | 1 | Volume block finished its ramp-down |
| stageEnable | output | 1 | Power stage switching enable |
| rampDownReq | output | 1 | Request to ramp the volume down |
| rampUpReq | output | 1 | One-cycle request to ramp the volume up |
| faultStatus | output | 4 | {clock error, over-current, DC, over-temperature} |
| faultN | output | 1 | Open-drain fault indication, 0 = pulled low |
| mode | output | 3 | Current operating mode |

## Verification
The hardest condition to reach is a clock error seen before active has ever been reached, since power-up normally runs straight into active. The stimulus shuts the block down, holds the sleep bit high while leaving shutdown, and only then raises the clock error. It counts low cycles of `faultN` over a whole number of pulse periods, then repeats the count from active to show the continuous level. The recovery intervals are separated by clearing a DC-only fault and an over-current fault in turn. For each, `faultN` is sampled at a point that falls between the short and the long interval.

// File: rtl/amp_sup_pkg.sv
package amp_sup_pkg;
  typedef enum logic [2:0] {
    MODE_SHDN   = 3'd0,
    MODE_SLEEP  = 3'd1,
    MODE_MUTED  = 3'd2,
    MODE_ACTIVE = 3'd3,
    MODE_RAMPDN = 3'd4
  } pwr_mode_e;

  // strobes from the mode controller to the fault datapath
  typedef struct packed {
    logic faultClr;  // a shutdown control is low: clear latched faults
    logic inShdn;    // controller sits in shutdown
    logic inActive;  // controller sits in active playback
  } sup_strobe_t;
endpackage

// File: rtl/amp_sup_ctrl.sv
module amp_sup_ctrl
  import amp_sup_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        shdnPinN,
  input  logic        shdnBitN,
  input  logic        sleepBit,
  input  logic        muteBit,
  input  logic        supplyOk,
  input  logic        holdOff,
  input  logic        rampDone,
  output pwr_mode_e   stateQ,
  output logic        stageEnable,
  output logic        rampDownReq,
  output logic        rampUpReq,
  output sup_strobe_t strb
);
  pwr_mode_e target;
  pwr_mode_e stateNext;
  logic shdnReq;
  logic hardStop;

  assign shdnReq  = ~shdnPinN | ~shdnBitN | ~supplyOk;
  assign hardStop = holdOff | ~supplyOk;

  always_comb begin
    if (shdnReq)                target = MODE_SHDN;
    else if (sleepBit | holdOff) target = MODE_SLEEP;
    else if (muteBit)           target = MODE_MUTED;
    else                        target = MODE_ACTIVE;
  end

  always_comb begin
    stateNext = target;
    unique case (stateQ)
      MODE_ACTIVE: begin
        if (hardStop)                  stateNext = target;
        else if (target != MODE_ACTIVE) stateNext = MODE_RAMPDN;
        else                           stateNext = MODE_ACTIVE;
      end
      MODE_RAMPDN: begin
        if (hardStop)                  stateNext = target;
        else if (target == MODE_ACTIVE) stateNext = MODE_ACTIVE;
        else if (rampDone)             stateNext = target;
        else                           stateNext = MODE_RAMPDN;
      end
      default: stateNext = target;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= MODE_SHDN;
      rampUpReq <= 1'b0;
    end else begin
      stateQ    <= stateNext;
      rampUpReq <= (stateNext == MODE_ACTIVE) && (stateQ != MODE_ACTIVE);
    end
  end

  assign stageEnable   = (stateQ == MODE_MUTED) || (stateQ == MODE_ACTIVE) ||
                         (stateQ == MODE_RAMPDN);
  assign rampDownReq   = (stateQ == MODE_RAMPDN);
  assign strb.faultClr = ~shdnPinN | ~shdnBitN;
  assign strb.inShdn   = (stateQ == MODE_SHDN);
  assign strb.inActive = (stateQ == MODE_ACTIVE);

  AST_SHDN_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (shdnReq && stateQ != MODE_ACTIVE && stateQ != MODE_RAMPDN) |=> (stateQ == MODE_SHDN)); // R1
  AST_RAMPUP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rampUpReq |=> !rampUpReq); // R2
  AST_RAMP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == MODE_RAMPDN && !rampDone && !hardStop && target != MODE_ACTIVE)
      |=> (stateQ == MODE_RAMPDN && stageEnable)); // R3
  AST_HOLD_BLOCKS_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    holdOff |=> (stateQ != MODE_ACTIVE)); // R4
endmodule

// File: rtl/amp_sup_dp.sv
module amp_sup_dp
  import amp_sup_pkg::*;
#(
  parameter int SHORT_WAIT   = 650000,
  parameter int LONG_WAIT    = 1300000,
  parameter int PULSE_LOW    = 10,
  parameter int PULSE_PERIOD = 350
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        usTick,
  input  logic        rawOverTemp,
  input  logic        rawDcErr,
  input  logic        rawOverCur,
  input  logic        rawClkErr,
  input  sup_strobe_t strb,
  output logic        holdOff,
  output logic [3:0]  faultStatus,
  output logic        faultN
);
  localparam int NUM_LATCH = 3;
  localparam int WAIT_W    = $clog2(LONG_WAIT + 1);
  localparam int PER_W     = $clog2(PULSE_PERIOD + 1);

  logic [NUM_LATCH-1:0] rawVec;
  logic [NUM_LATCH-1:0] latQ;
  logic [WAIT_W-1:0]    waitCnt;
  logic [PER_W-1:0]     pulseCnt;
  logic                 beenActive;
  logic                 waitBusy;
  logic                 pulseLow;
  logic                 clkPinLow;

  assign rawVec = {rawOverCur, rawDcErr, rawOverTemp};

  for (genvar gi = 0; gi < NUM_LATCH; gi++) begin : g_latch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              latQ[gi] <= 1'b0;
      else if (strb.faultClr) latQ[gi] <= 1'b0;
      else if (rawVec[gi])    latQ[gi] <= 1'b1;
    end
  end

  // recovery interval, chosen by the kinds of fault being cleared
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) waitCnt <= '0;
    else if (strb.faultClr && (|latQ))
      waitCnt <= (latQ[0] | latQ[2]) ? WAIT_W'(LONG_WAIT) : WAIT_W'(SHORT_WAIT);
    else if (usTick && waitCnt != '0)
      waitCnt <= waitCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseCnt <= '0;
    else if (!rawClkErr) pulseCnt <= '0;
    else if (usTick)
      pulseCnt <= (pulseCnt == PER_W'(PULSE_PERIOD - 1)) ? '0 : pulseCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              beenActive <= 1'b0;
    else if (strb.inShdn)   beenActive <= 1'b0;
    else if (strb.inActive) beenActive <= 1'b1;
  end

  assign waitBusy    = (waitCnt != '0);
  assign pulseLow    = (pulseCnt < PER_W'(PULSE_LOW));
  assign clkPinLow   = rawClkErr && !strb.inShdn && (beenActive || pulseLow);
  assign holdOff     = (|latQ) | waitBusy | (|rawVec) | rawClkErr;
  assign faultStatus = {rawClkErr | strb.inShdn, latQ};
  assign faultN      = ~((|latQ) | waitBusy | clkPinLow);

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strb.faultClr |=> ((latQ & $past(latQ)) == $past(latQ))); // R4
  AST_WAIT_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    strb.inActive |-> (waitCnt == '0)); // R8
  AST_PULSE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt < PER_W'(PULSE_PERIOD)); // R7
endmodule

// File: rtl/amp_mode_supervisor.sv
module amp_mode_supervisor
  import amp_sup_pkg::*;
#(
  parameter int SHORT_WAIT   = 650000,
  parameter int LONG_WAIT    = 1300000,
  parameter int PULSE_LOW    = 10,
  parameter int PULSE_PERIOD = 350
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       usTick,
  input  logic       shdnPinN,
  input  logic       shdnBitN,
  input  logic       sleepBit,
  input  logic       muteBit,
  input  logic       supplyOk,
  input  logic       rawOverTemp,
  input  logic       rawDcErr,
  input  logic       rawOverCur,
  input  logic       rawClkErr,
  input  logic       rampDone,
  output logic       stageEnable,
  output logic       rampDownReq,
  output logic       rampUpReq,
  output logic [3:0] faultStatus,
  output logic       faultN,
  output logic [2:0] mode
);
  sup_strobe_t strb;
  pwr_mode_e   stateQ;
  logic        holdOff;

  amp_sup_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .shdnPinN(shdnPinN), .shdnBitN(shdnBitN),
    .sleepBit(sleepBit), .muteBit(muteBit), .supplyOk(supplyOk),
    .holdOff(holdOff), .rampDone(rampDone), .stateQ(stateQ),
    .stageEnable(stageEnable), .rampDownReq(rampDownReq),
    .rampUpReq(rampUpReq), .strb(strb)
  );

  amp_sup_dp #(
    .SHORT_WAIT(SHORT_WAIT), .LONG_WAIT(LONG_WAIT),
    .PULSE_LOW(PULSE_LOW), .PULSE_PERIOD(PULSE_PERIOD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .usTick(usTick), .rawOverTemp(rawOverTemp),
    .rawDcErr(rawDcErr), .rawOverCur(rawOverCur), .rawClkErr(rawClkErr),
    .strb(strb), .holdOff(holdOff), .faultStatus(faultStatus), .faultN(faultN)
  );

  assign mode = stateQ;
endmodule

// File: tb/amp_mode_supervisor_bench.sv
`timescale 1ns/1ps
module amp_mode_supervisor_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usTick = 1'b1;
  logic shdnPinN = 1'b1, shdnBitN = 1'b1, sleepBit = 1'b0, muteBit = 1'b0;
  logic supplyOk = 1'b1, rampDone = 1'b1;
  logic rawOverTemp = 1'b0, rawDcErr = 1'b0, rawOverCur = 1'b0, rawClkErr = 1'b0;
  logic stageEnable, rampDownReq, rampUpReq, faultN;
  logic [3:0] faultStatus;
  logic [2:0] mode;
  int checks = 0;
  int fails = 0;
  int lows;

  always #2.5 clk = ~clk;

  amp_mode_supervisor #(.SHORT_WAIT(20), .LONG_WAIT(40), .PULSE_LOW(3), .PULSE_PERIOD(10))
  u_amp_mode_supervisor (
    .clk(clk), .rstN(rstN), .usTick(usTick), .shdnPinN(shdnPinN), .shdnBitN(shdnBitN),
    .sleepBit(sleepBit), .muteBit(muteBit), .supplyOk(supplyOk),
    .rawOverTemp(rawOverTemp), .rawDcErr(rawDcErr), .rawOverCur(rawOverCur),
    .rawClkErr(rawClkErr), .rampDone(rampDone), .stageEnable(stageEnable),
    .rampDownReq(rampDownReq), .rampUpReq(rampUpReq), .faultStatus(faultStatus),
    .faultN(faultN), .mode(mode)
  );

  // {pinN, bitN, sleep, mute, supply, expected mode[2:0], expected enable}
  localparam logic [8:0] VEC [11] = '{
    {5'b11001, 3'd3, 1'b1}, {5'b11011, 3'd2, 1'b1}, {5'b11001, 3'd3, 1'b1},
    {5'b11101, 3'd1, 1'b0}, {5'b11001, 3'd3, 1'b1}, {5'b01001, 3'd0, 1'b0},
    {5'b10001, 3'd0, 1'b0}, {5'b11000, 3'd0, 1'b0}, {5'b11011, 3'd2, 1'b1},
    {5'b11111, 3'd1, 1'b0}, {5'b11001, 3'd3, 1'b1}
  };

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic countLows(input int n);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (!faultN) lows++;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(3);
    // R10 reset state
    check("R10 mode", mode, 3'd0);
    check("R10 enable", stageEnable, 1'b0);
    check("R10 ramps", {rampUpReq, rampDownReq}, 2'b00);
    check("R10 faultN", faultN, 1'b1);
    check("R10 status", faultStatus, 4'b1000);
    rstN = 1'b1;

    // R1 R2 R3 R9 table walk
    for (int v = 0; v < 11; v++) begin
      {shdnPinN, shdnBitN, sleepBit, muteBit, supplyOk} = VEC[v][8:4];
      step(4);
      check("R1/R2 table mode", mode, VEC[v][3:1]);
      check("R1/R2 table enable", stageEnable, VEC[v][0]);
    end

    // R3 ramp-down waits for rampDone
    rampDone = 1'b0; muteBit = 1'b1; step(3);
    check("R3 ramp mode", mode, 3'd4);
    check("R3 ramp req/enable", {rampDownReq, stageEnable}, 2'b11);
    rampDone = 1'b1; step(2);
    check("R3 muted after done", mode, 3'd2);
    // R2 ramp-up pulse
    muteBit = 1'b0; step(1);
    check("R2 rampUp first cycle", {mode, rampUpReq}, {3'd3, 1'b1});
    step(1);
    check("R2 rampUp single", rampUpReq, 1'b0);

    // R4 R8 over-temperature latch and long recovery
    rawOverTemp = 1'b1; step(1); rawOverTemp = 1'b0; step(1);
    check("R4 OT sleep", mode, 3'd1);
    check("R4 OT status", faultStatus, 4'b0001);
    check("R4 OT faultN", faultN, 1'b0);
    sleepBit = 1'b1; step(3); sleepBit = 1'b0; step(3);
    check("R4 sleep no clear", faultStatus, 4'b0001);
    shdnPinN = 1'b0; step(2);
    check("R4 R6 cleared in shdn", faultStatus, 4'b1000);
    shdnPinN = 1'b1; step(30);
    check("R8 OT still waiting", {mode, faultN}, {3'd1, 1'b0});
    step(15);
    check("R8 OT released", {mode, faultN}, {3'd3, 1'b1});

    // R8 DC-only short recovery
    rawDcErr = 1'b1; step(1); rawDcErr = 1'b0; step(1);
    check("R4 DC status", faultStatus, 4'b0010);
    shdnBitN = 1'b0; step(2); shdnBitN = 1'b1; step(15);
    check("R8 DC waiting", faultN, 1'b0);
    step(8);
    check("R8 DC short release", {mode, faultN}, {3'd3, 1'b1});

    // R8 over-current uses the long interval
    rawOverCur = 1'b1; step(1); rawOverCur = 1'b0; step(1);
    check("R4 OC status", faultStatus, 4'b0100);
    shdnPinN = 1'b0; step(2); shdnPinN = 1'b1; step(25);
    check("R8 OC long wait", {mode, faultN}, {3'd1, 1'b0});
    step(20);
    check("R8 OC released", {mode, faultN}, {3'd3, 1'b1});

    // R9 supply dropout keeps latch
    rawDcErr = 1'b1; step(1); rawDcErr = 1'b0;
    supplyOk = 1'b0; step(3);
    check("R9 dropout shdn", mode, 3'd0);
    supplyOk = 1'b1; step(3);
    check("R9 latch kept", {mode, faultStatus[1], faultN}, {3'd1, 1'b1, 1'b0});
    shdnBitN = 1'b0; step(2); shdnBitN = 1'b1; step(25);
    check("R9 resumes", mode, 3'd3);

    // R5 R7 clock error after active: immediate sleep, continuous fault
    rawClkErr = 1'b1; step(1);
    check("R5 clk sleep immediate", {mode, stageEnable, rampDownReq}, {3'd1, 2'b00});
    check("R5 clk status", faultStatus, 4'b1000);
    countLows(30);
    check("R7 continuous low", lows, 30);
    rawClkErr = 1'b0; step(1);
    check("R5 return with ramp", {mode, rampUpReq}, {3'd3, 1'b1});
    check("R5 status self clear", faultStatus, 4'b0000);

    // R7 clock error before first active: pulsed fault
    shdnPinN = 1'b0; step(2);
    sleepBit = 1'b1; shdnPinN = 1'b1; step(2);
    check("R7 setup sleep", mode, 3'd1);
    rawClkErr = 1'b1; step(3);
    countLows(30);
    check("R7 pulsed low count", lows, 9);
    rawClkErr = 1'b0; sleepBit = 1'b0; step(3);
    check("R2 active again", mode, 3'd3);

    // R6 shutdown reads clock error bit
    shdnPinN = 1'b0; step(4);
    check("R6 shdn clk bit", {mode, faultStatus}, {3'd0, 4'b1000});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule